// File: doc/BRIEF.md
# Streaming Running-Maximum Filter

This block slides a window of `WIN` samples along a stream of unsigned pixels and reports the largest value inside the window. It produces one result for each accepted input sample. It never compares all `WIN` samples at once. Instead it splits the stream into back-to-back segments of `WIN` samples, counted from the first sample after reset, and works out two partial results. One is a running maximum that moves forward through each segment (prefix maxima). The other is a running maximum over a segment played back in reverse (suffix maxima). For any window, one suffix value and one prefix value together cover exactly `WIN` samples, so a single comparison gives the result.

Reversal and realignment use small buffers of `WIN` entries, each with one port. In each cycle a buffer reads and writes one shared address, and the read happens before the write. The buffers that reverse data change their address direction after every segment, so each buffer returns the previous segment mirrored while the current segment is written in. The pipeline moves forward only on cycles where the input strobe is high. Idle cycles freeze all state.

Top module: `run_max_stream`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` is 1 only in the cycle that follows an accepted sample (`in_valid` high at the clock edge). It stays 0 for the first `2*WIN` samples accepted after reset, numbered 0 to `2*WIN-1`.
- R3: When sample number n is accepted with n ≥ `2*WIN`, the next cycle shows `out_valid`=1 and `out_data` equal to the maximum of samples n-2·`WIN` through n-`WIN`-1.
- R4: A cycle with `in_valid` low advances nothing. The following cycle shows `out_valid`=0 and an unchanged `out_data`, and later results are the same as if the idle cycle had never happened.
- R5: Results are correct wherever the window falls relative to the segments. This includes a window that starts on the first sample of a segment and windows that cross a segment boundary, under both rising and falling ramps.
- R6: Applying reset in the middle of a stream discards all history. The warm-up of `2*WIN` samples from R2 begins again.
- R7: The full value range is handled, including streams that are all 0 and all 2^`DW`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DW | Unsigned input sample |
| out_valid | output | 1 | `out_data` holds a new window maximum |
| out_data | output | DW | Window maximum, held between results |

## Verification
The sensitive cycle is the one where a buffer hands out the last entry of the old segment while the first entry of the new segment lands at the same address, and the direction flip and the running-maximum restart take effect on that same edge. The bench provokes this with ramps: a falling ramp puts each window's maximum at its oldest sample, and a rising ramp puts it at its newest. It also inserts idle gaps right at segment ends, so that the restart and a stall meet. Every result is compared with a maximum the bench computes itself from its own record of the accepted samples.

// File: rtl/run_max_stream.sv
module run_max_stream #(
  parameter int WIN = 5,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int AW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [AW-1:0] LAST = AW'(WIN - 1);

  function automatic logic [DW-1:0] max2(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [AW-1:0] pos;
  logic          dir;
  logic [1:0]    seg_seen;
  logic [DW-1:0] fwd_q, bwd_q;
  logic [DW-1:0] raw_mem [WIN];
  logic [DW-1:0] suf_mem [WIN];
  logic [DW-1:0] pre_mem [WIN];

  wire           seg_end = (pos == LAST);
  wire           primed  = (seg_seen == 2'd2);
  wire [AW-1:0]  addr    = dir ? (LAST - pos) : pos;
  wire [DW-1:0]  raw_old = raw_mem[addr];
  wire [DW-1:0]  bwd_now = (pos == '0) ? raw_old : max2(bwd_q, raw_old);
  wire [DW-1:0]  suf_old = suf_mem[addr];
  wire [DW-1:0]  pre_old = pre_mem[pos];
  wire [DW-1:0]  merged  = (pos == '0) ? suf_old : max2(suf_old, pre_old);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      dir       <= 1'b0;
      seg_seen  <= 2'd0;
      fwd_q     <= '0;
      bwd_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid && primed;
      if (in_valid) begin
        pos   <= seg_end ? '0 : pos + 1'b1;
        fwd_q <= (pos == '0) ? in_data : max2(fwd_q, in_data);
        bwd_q <= bwd_now;
        if (seg_end) begin
          dir <= ~dir;
          if (!primed) seg_seen <= seg_seen + 2'd1;
        end
        if (primed) out_data <= merged;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      raw_mem[addr] <= in_data;
      suf_mem[addr] <= bwd_now;
      pre_mem[pos]  <= fwd_q;
    end
  end

  AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R4
  AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R2
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST); // R5
  AST_DIR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seg_end) |=> (dir != $past(dir)) && (pos == '0)); // R5
  AST_FWD_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos != '0) |=> fwd_q >= $past(fwd_q)); // R3
  AST_BWD_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos != '0) |=> bwd_q >= $past(bwd_q)); // R3
  AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos) && $stable(dir) && $stable(fwd_q)); // R4

  initial begin
    AST_WIN_MIN: assert (WIN >= 2); // R3
  end
endmodule

// File: tb/run_max_stream_tb.sv
`timescale 1ns/1ps
module run_max_stream_tb;
  localparam int WIN = 5;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int checks = 0;
  int failures = 0;
  int cnt = 0;
  logic [DW-1:0] hist [1024];
  logic [DW-1:0] last_data = '0;
  bit done = 0;

  always #4 clk = ~clk;

  run_max_stream #(.WIN(WIN), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    @(negedge clk);
    check("R1 valid in reset", {8'd0, out_valid}, 9'd0);
    check("R1 data in reset", {1'b0, out_data}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {8'd0, out_valid}, 9'd0);
    check("R1 data after reset", {1'b0, out_data}, 9'd0);
    cnt = 0;
    last_data = '0;
  endtask

  task automatic push(input string req, input logic v, input logic [DW-1:0] d);
    logic exp_v;
    logic [DW-1:0] exp_d;
    exp_v = 1'b0;
    exp_d = last_data;
    in_valid = v;
    in_data = d;
    if (v) begin
      hist[cnt] = d;
      if (cnt >= 2*WIN) begin
        exp_v = 1'b1;
        exp_d = '0;
        for (int j = cnt - 2*WIN; j <= cnt - WIN - 1; j++)
          if (hist[j] > exp_d) exp_d = hist[j];
      end
      cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {8'd0, out_valid}, {8'd0, exp_v});
    check({req, " data"}, {1'b0, out_data}, {1'b0, exp_d});
    last_data = exp_d;
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 150; i++) push("R3 random", 1'b1, DW'($urandom));
  endtask

  task automatic t_ramp_up();
    do_reset();
    for (int i = 0; i < 60; i++) push("R5 rising ramp", 1'b1, DW'(i * 3));
  endtask

  task automatic t_ramp_down();
    do_reset();
    for (int i = 0; i < 60; i++) push("R5 falling ramp", 1'b1, DW'(250 - i * 4));
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 80; i++) begin
      push("R2 warmup/gap stream", 1'b1, DW'($urandom));
      if ((cnt % WIN) == 0 || (i % 7) == 3) push("R4 idle cycle", 1'b0, DW'($urandom));
    end
  endtask

  task automatic t_extremes();
    do_reset();
    for (int i = 0; i < 25; i++) push("R7 all zero", 1'b1, '0);
    for (int i = 0; i < 25; i++) push("R7 all max", 1'b1, '1);
    for (int i = 0; i < 25; i++) push("R7 alternate", 1'b1, (i % 2) ? '1 : '0);
  endtask

  task automatic t_restart();
    do_reset();
    for (int i = 0; i < 17; i++) push("R6 before reset", 1'b1, DW'(200 + i));
    do_reset();
    for (int i = 0; i < 30; i++) push("R6 after reset", 1'b1, DW'(i));
  endtask

  initial begin
    t_random();
    t_ramp_up();
    t_ramp_down();
    t_gaps();
    t_extremes();
    t_restart();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule